// File: doc/BRIEF.md
# Operand Address and Stack Unit

This unit sits between the instruction decoder and memory of a small 8-bit processor. The decoder supplies an addressing mode, the one or two operand bytes that follow the opcode, the X and Y index registers, a branch condition and a byte to push. The unit then produces either a 16-bit effective address or the next program counter. It owns the 8-bit stack pointer.

Some modes need a pointer or return address from memory, or must write to the stack. For these the unit runs a short sequence on a one-port memory request interface and holds `busy` high while it does so. A read issued in one cycle (`mem_req` high, `mem_we` low) must return its byte on `mem_rdata` in the following cycle. Writes complete in the cycle they are issued.

`start` is sampled only while `busy` is low. In every mode, `done` pulses for one cycle when the results are valid. `pc_in` is the address of the byte after the instruction's operands.

Top module: `addr_stack_unit`

## Requirements
- R1: After reset the stack pointer `sp` is 0xFF, and `done`, `busy` and `pc_load` are low.
- R2: Modes 0, 1 and 2 (page-zero, page-zero+X, page-zero+Y) give `ea` = {0x00, op_lo + index}, with the sum wrapping in 8 bits. `done` is high in the cycle right after the start edge.
- R3: Modes 3, 4 and 5 (absolute, absolute+X, absolute+Y) give `ea` = {op_hi, op_lo} plus the zero-extended index, in 16 bits. `done` is high in the cycle right after the start edge.
- R4: Mode 6 (pre-indexed) forms p = op_lo + X, wrapping in 8 bits. It reads the low byte at {0x00,p} and the high byte at {0x00,p+1}, with p+1 also wrapping in 8 bits, and returns that word as `ea`. `done` follows 4 cycles after start.
- R5: Mode 7 (post-indexed) reads a word, low byte first, at {0x00,op_lo} and {0x00,op_lo+1}, with op_lo+1 wrapping in 8 bits. `ea` is that word plus Y in 16 bits. `done` follows 4 cycles after start.
- R6: Mode 9 (indirect jump) reads a word at {op_hi,op_lo} and at that address +1 (16-bit increment), loads it into `next_pc` and raises `pc_load`. `done` follows 4 cycles after start.
- R7: Mode 8 (jump) sets `next_pc` = {op_hi, op_lo} with `pc_load` high, one cycle after start.
- R8: Mode 10 (branch): when `cond_ok` is 1, `next_pc` = pc_in plus op_lo read as a signed 8-bit value and `br_cycles` = 3. Otherwise `next_pc` = pc_in and `br_cycles` = 2. Either way `pc_load` is high and the result is ready one cycle after start.
- R9: Mode 13 (push) writes `push_data` to 0x0100+sp, then decrements sp, wrapping 0x00 to 0xFF. `done` follows 2 cycles after start.
- R10: Mode 14 (pull) increments sp first, then reads 0x0100+sp into `pull_data`. `done` follows 3 cycles after start.
- R11: Mode 11 (call) pushes the high byte and then the low byte of pc_in-1, so sp drops by 2. It then sets `next_pc` = {op_hi, op_lo}. `done` follows 3 cycles after start.
- R12: Mode 12 (return) pulls the low byte and then the high byte, so sp rises by 2, and sets `next_pc` to that word plus 1. `done` follows 4 cycles after start.
- R13: Mode 15 loads sp from X, one cycle after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled while not busy) |
| mode | input | 4 | Addressing or stack mode, encoded as in the requirements |
| op_lo | input | 8 | First operand byte |
| op_hi | input | 8 | Second operand byte |
| pc_in | input | 16 | Address after the operand bytes |
| x_idx | input | 8 | X index register |
| y_idx | input | 8 | Y index register |
| cond_ok | input | 1 | Branch condition is true |
| push_data | input | 8 | Byte for push mode |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| busy | output | 1 | Multi-cycle sequence in progress |
| done | output | 1 | One-cycle pulse: results valid |
| ea | output | 16 | Effective address |
| next_pc | output | 16 | Program counter to load |
| pc_load | output | 1 | next_pc is meaningful for this operation |
| br_cycles | output | 2 | Branch cost, 2 or 3 cycles |
| pull_data | output | 8 | Byte returned by pull mode |
| sp | output | 8 | Stack pointer |

## Verification
The sweeps drive indices and operands so that page-zero sums and pointer addresses cross 0xFF. A design that carried into page one on the pre-indexed pointer's high byte, or on a page-zero indexed address, would return a word built from the wrong bytes.

The branch sweep covers all 256 offsets with the condition both true and false, from a base near zero. This exposes unsigned offsets and a wrong penalty count.

Stack checks move sp through 0x00 and read back through pull and return. Swapped byte order, an off-by-one return address, or decrement-before-write would appear as a wrong `pull_data` or `next_pc`.

// File: rtl/addr_stack_unit.sv
module addr_stack_unit #(
  parameter logic [7:0] STACK_PAGE = 8'h01,
  parameter logic [7:0] SP_RESET   = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  mode,
  input  logic [7:0]  op_lo,
  input  logic [7:0]  op_hi,
  input  logic [15:0] pc_in,
  input  logic [7:0]  x_idx,
  input  logic [7:0]  y_idx,
  input  logic        cond_ok,
  input  logic [7:0]  push_data,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] ea,
  output logic [15:0] next_pc,
  output logic        pc_load,
  output logic [1:0]  br_cycles,
  output logic [7:0]  pull_data,
  output logic [7:0]  sp
);
  localparam logic [3:0] M_ZP = 4'd0, M_ZPX = 4'd1, M_ZPY = 4'd2, M_ABS = 4'd3,
    M_ABSX = 4'd4, M_ABSY = 4'd5, M_INDX = 4'd6, M_INDY = 4'd7, M_JMP = 4'd8,
    M_JIND = 4'd9, M_BR = 4'd10, M_CALL = 4'd11, M_RET = 4'd12, M_PUSH = 4'd13,
    M_PULL = 4'd14, M_SPLD = 4'd15;

  typedef enum logic [2:0] {S_IDLE, S_RD1, S_RD2, S_FIN, S_WR1, S_WR2} st_t;
  st_t st;

  logic [3:0]  md;
  logic [7:0]  b0, b1, yv, dat, lo_r;
  logic [15:0] ret;

  wire [7:0]  sp_up = sp + 8'd1;
  wire [7:0]  zx    = op_lo + x_idx;
  wire [7:0]  zy    = op_lo + y_idx;
  wire [7:0]  b0_n  = b0 + 8'd1;
  wire [15:0] word  = {mem_rdata, lo_r};
  wire [15:0] bword = {b1, b0};

  assign busy    = (st != S_IDLE);
  assign mem_req = (st != S_IDLE) && (st != S_FIN);
  assign mem_we  = (st == S_WR1) || (st == S_WR2);
  assign mem_wdata = (st == S_WR1) ? ret[15:8] : ((md == M_CALL) ? ret[7:0] : dat);

  always_comb begin
    mem_addr = 16'h0000;
    case (st)
      S_RD1: case (md)
        M_INDX, M_INDY: mem_addr = {8'h00, b0};
        M_JIND:         mem_addr = bword;
        default:        mem_addr = {STACK_PAGE, sp_up};
      endcase
      S_RD2: case (md)
        M_INDX, M_INDY: mem_addr = {8'h00, b0_n};
        M_JIND:         mem_addr = bword + 16'd1;
        default:        mem_addr = {STACK_PAGE, sp_up};
      endcase
      S_WR1, S_WR2: mem_addr = {STACK_PAGE, sp};
      default: mem_addr = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; sp <= SP_RESET; done <= 1'b0; pc_load <= 1'b0;
      ea <= '0; next_pc <= '0; br_cycles <= '0; pull_data <= '0;
      md <= '0; b0 <= '0; b1 <= '0; yv <= '0; dat <= '0; lo_r <= '0; ret <= '0;
    end else begin
      done <= 1'b0;
      pc_load <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          md  <= mode;
          b0  <= (mode == M_INDX) ? zx : op_lo;
          b1  <= op_hi;
          yv  <= y_idx;
          dat <= push_data;
          ret <= pc_in - 16'd1;
          case (mode)
            M_ZP:   begin ea <= {8'h00, op_lo}; done <= 1'b1; end
            M_ZPX:  begin ea <= {8'h00, zx}; done <= 1'b1; end
            M_ZPY:  begin ea <= {8'h00, zy}; done <= 1'b1; end
            M_ABS:  begin ea <= {op_hi, op_lo}; done <= 1'b1; end
            M_ABSX: begin ea <= {op_hi, op_lo} + {8'h00, x_idx}; done <= 1'b1; end
            M_ABSY: begin ea <= {op_hi, op_lo} + {8'h00, y_idx}; done <= 1'b1; end
            M_JMP:  begin next_pc <= {op_hi, op_lo}; pc_load <= 1'b1; done <= 1'b1; end
            M_BR: begin
              next_pc   <= cond_ok ? pc_in + {{8{op_lo[7]}}, op_lo} : pc_in;
              br_cycles <= cond_ok ? 2'd3 : 2'd2;
              pc_load   <= 1'b1;
              done      <= 1'b1;
            end
            M_SPLD: begin sp <= x_idx; done <= 1'b1; end
            M_CALL: st <= S_WR1;
            M_PUSH: st <= S_WR2;
            default: st <= S_RD1;
          endcase
        end
        S_RD1: begin
          if (md == M_RET || md == M_PULL) sp <= sp_up;
          st <= (md == M_PULL) ? S_FIN : S_RD2;
        end
        S_RD2: begin
          lo_r <= mem_rdata;
          if (md == M_RET) sp <= sp_up;
          st <= S_FIN;
        end
        S_FIN: begin
          st <= S_IDLE;
          done <= 1'b1;
          case (md)
            M_PULL: pull_data <= mem_rdata;
            M_INDX: ea <= word;
            M_INDY: ea <= word + {8'h00, yv};
            M_JIND: begin next_pc <= word; pc_load <= 1'b1; end
            default: begin next_pc <= word + 16'd1; pc_load <= 1'b1; end
          endcase
        end
        S_WR1: begin sp <= sp - 8'd1; st <= S_WR2; end
        S_WR2: begin
          sp <= sp - 8'd1;
          st <= S_IDLE;
          done <= 1'b1;
          if (md == M_CALL) begin next_pc <= bword; pc_load <= 1'b1; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  zp_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (md == M_ZP || md == M_ZPX || md == M_ZPY) |-> ea[15:8] == 8'h00);
  // R4 R5
  ptr_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && (md == M_INDX || md == M_INDY) |-> mem_addr[15:8] == 8'h00);
  // R9 R11
  wr_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[15:8] == STACK_PAGE);
  // R8
  br_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && md == M_BR |-> br_cycles == ($past(cond_ok) ? 2'd3 : 2'd2));
  // R9
  push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && md == M_PUSH |-> sp == $past(sp) - 8'd1);
  // R11
  call_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && md == M_CALL |-> sp == $past(sp, 2) - 8'd2);
  // R12
  ret_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && md == M_RET |-> sp == $past(sp, 3) + 8'd2);
endmodule

// File: tb/tb_addr_stack_unit.sv
module tb_addr_stack_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cond_ok = 1'b0;
  logic [3:0] mode = '0;
  logic [7:0] op_lo = '0, op_hi = '0, x_idx = '0, y_idx = '0, push_data = '0;
  logic [15:0] pc_in = '0;
  logic mem_req, mem_we, busy, done, pc_load;
  logic [15:0] mem_addr, ea, next_pc;
  logic [7:0] mem_wdata, pull_data, sp;
  logic [7:0] mem_rdata = '0;
  logic [1:0] br_cycles;

  int total = 0, bad = 0, lat = 0;
  logic [7:0] stk [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_stack_unit dut (.clk, .rst_n, .start, .mode, .op_lo, .op_hi, .pc_in, .x_idx, .y_idx,
    .cond_ok, .push_data, .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .busy,
    .done, .ea, .next_pc, .pc_load, .br_cycles, .pull_data, .sp);

  function automatic logic [7:0] mbyte(input logic [15:0] a);
    return a[7:0] + a[15:8] * 8'd7 + 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (mem_req && !mem_we)
      mem_rdata <= (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] : mbyte(mem_addr);
    if (mem_req && mem_we && mem_addr[15:8] == 8'h01)
      stk[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                     input logic [15:0] pc, input logic [7:0] x, input logic [7:0] y,
                     input logic c, input logic [7:0] pd);
    @(negedge clk);
    mode = m; op_lo = lo; op_hi = hi; pc_in = pc; x_idx = x; y_idx = y;
    cond_ok = c; push_data = pd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) stk[i] = 8'hEE;
    repeat (3) @(negedge clk);
    // R1
    chk(sp == 8'hFF, "R1 sp", sp, 8'hFF);
    chk(!done && !busy && !pc_load, "R1 flags", {done, busy, pc_load}, 0);
    rst_n = 1'b1;

    // R2 page-zero with 8-bit wrap
    for (int lo = 0; lo < 256; lo += 17)
      for (int x = 0; x < 256; x += 37) begin
        logic [7:0] s;
        s = 8'(lo) + 8'(x);
        run(4'd1, 8'(lo), 8'h55, 16'h0, 8'(x), 8'h0, 1'b0, 8'h0);
        chk(ea == {8'h00, s} && lat == 1, "R2 zpx", {ea, 8'(lat)}, {8'h00, s, 8'd1});
        run(4'd2, 8'(lo), 8'h55, 16'h0, 8'h0, 8'(x), 1'b0, 8'h0);
        chk(ea == {8'h00, s}, "R2 zpy", ea, {8'h00, s});
      end
    run(4'd0, 8'hC3, 8'h77, 16'h0, 8'h10, 8'h10, 1'b0, 8'h0);
    chk(ea == 16'h00C3, "R2 zp", ea, 16'h00C3);

    // R3 absolute with 16-bit carry
    for (int hi = 0; hi < 256; hi += 51)
      for (int x = 0; x < 256; x += 29) begin
        logic [15:0] e;
        e = {8'(hi), 8'hE0} + 16'(x);
        run(4'd4, 8'hE0, 8'(hi), 16'h0, 8'(x), 8'h0, 1'b0, 8'h0);
        chk(ea == e && lat == 1, "R3 absx", ea, e);
        run(4'd5, 8'hE0, 8'(hi), 16'h0, 8'h0, 8'(x), 1'b0, 8'h0);
        chk(ea == e, "R3 absy", ea, e);
      end
    run(4'd3, 8'h34, 8'h12, 16'h0, 8'hFF, 8'hFF, 1'b0, 8'h0);
    chk(ea == 16'h1234, "R3 abs", ea, 16'h1234);

    // R4 pre-indexed, pointer high-byte wrap in page zero
    for (int lo = 0; lo < 256; lo += 13)
      for (int x = 0; x < 256; x += 85) begin
        logic [7:0] p, p1;
        logic [15:0] e;
        p = 8'(lo) + 8'(x); p1 = p + 8'd1;
        e = {mbyte({8'h00, p1}), mbyte({8'h00, p})};
        run(4'd6, 8'(lo), 8'h00, 16'h0, 8'(x), 8'h0, 1'b0, 8'h0);
        chk(ea == e && lat == 4, "R4 indx", {ea, 8'(lat)}, {e, 8'd4});
      end

    // R5 post-indexed, pointer in page zero then +Y in 16 bits
    for (int lo = 250; lo < 256; lo++)
      for (int y = 0; y < 256; y += 63) begin
        logic [7:0] l1;
        logic [15:0] e;
        l1 = 8'(lo) + 8'd1;
        e = {mbyte({8'h00, l1}), mbyte({8'h00, 8'(lo)})} + 16'(y);
        run(4'd7, 8'(lo), 8'h00, 16'h0, 8'h0, 8'(y), 1'b0, 8'h0);
        chk(ea == e && lat == 4, "R5 indy", ea, e);
      end

    // R6 indirect jump across a page boundary
    begin
      logic [15:0] e;
      e = {mbyte(16'h1300), mbyte(16'h12FF)};
      run(4'd9, 8'hFF, 8'h12, 16'h0, 8'h0, 8'h0, 1'b0, 8'h0);
      chk(next_pc == e && pc_load && lat == 4, "R6 jind", next_pc, e);
    end

    // R7
    run(4'd8, 8'hCD, 8'hAB, 16'h4444, 8'h0, 8'h0, 1'b0, 8'h0);
    chk(next_pc == 16'hABCD && pc_load && lat == 1, "R7 jmp", next_pc, 16'hABCD);

    // R8 signed offset sweep, both conditions
    for (int o = 0; o < 256; o++)
      for (int c = 0; c < 2; c++) begin
        logic [15:0] e;
        e = c ? 16'h0010 + {{8{o[7]}}, 8'(o)} : 16'h0010;
        run(4'd10, 8'(o), 8'h00, 16'h0010, 8'h0, 8'h0, c[0], 8'h0);
        chk(next_pc == e && br_cycles == (c ? 2'd3 : 2'd2) && lat == 1,
            "R8 branch", {next_pc, 6'b0, br_cycles}, {e, 6'b0, c ? 2'd3 : 2'd2});
      end

    // R9 R10 push then pull, order and sp
    run(4'd13, 8'h0, 8'h0, 16'h0, 8'h0, 8'h0, 1'b0, 8'h11);
    chk(sp == 8'hFE && lat == 2, "R9 push sp", sp, 8'hFE);
    run(4'd13, 8'h0, 8'h0, 16'h0, 8'h0, 8'h0, 1'b0, 8'h22);
    run(4'd14, 8'h0, 8'h0, 16'h0, 8'h0, 8'h0, 1'b0, 8'h0);
    chk(pull_data == 8'h22 && sp == 8'hFE && lat == 3, "R10 pull", pull_data, 8'h22);
    run(4'd14, 8'h0, 8'h0, 16'h0, 8'h0, 8'h0, 1'b0, 8'h0);
    chk(pull_data == 8'h11 && sp == 8'hFF, "R10 pull2", pull_data, 8'h11);

    // R13 then R9 wrap at 0x00
    run(4'd15, 8'h0, 8'h0, 16'h0, 8'h00, 8'h0, 1'b0, 8'h0);
    chk(sp == 8'h00 && lat == 1, "R13 spld", sp, 8'h00);
    run(4'd13, 8'h0, 8'h0, 16'h0, 8'h0, 8'h0, 1'b0, 8'h9A);
    chk(sp == 8'hFF, "R9 wrap", sp, 8'hFF);
    run(4'd14, 8'h0, 8'h0, 16'h0, 8'h0, 8'h0, 1'b0, 8'h0);
    chk(pull_data == 8'h9A && sp == 8'h00, "R10 wrap", pull_data, 8'h9A);

    // R11 call byte order checked by pulls
    run(4'd15, 8'h0, 8'h0, 16'h0, 8'h80, 8'h0, 1'b0, 8'h0);
    run(4'd11, 8'h00, 8'h20, 16'h4567, 8'h0, 8'h0, 1'b0, 8'h0);
    chk(next_pc == 16'h2000 && pc_load && sp == 8'h7E && lat == 3, "R11 call", {next_pc, sp}, {16'h2000, 8'h7E});
    run(4'd14, 8'h0, 8'h0, 16'h0, 8'h0, 8'h0, 1'b0, 8'h0);
    chk(pull_data == 8'h66, "R11 low byte", pull_data, 8'h66);
    run(4'd14, 8'h0, 8'h0, 16'h0, 8'h0, 8'h0, 1'b0, 8'h0);
    chk(pull_data == 8'h45, "R11 high byte", pull_data, 8'h45);

    // R12 call then return
    run(4'd11, 8'h34, 8'h12, 16'hBEF0, 8'h0, 8'h0, 1'b0, 8'h0);
    run(4'd12, 8'h0, 8'h0, 16'h0, 8'h0, 8'h0, 1'b0, 8'h0);
    chk(next_pc == 16'hBEF0 && pc_load && sp == 8'h80 && lat == 4, "R12 ret", {next_pc, sp}, {16'hBEF0, 8'h80});
    run(4'd15, 8'h0, 8'h0, 16'h0, 8'hFE, 8'h0, 1'b0, 8'h0);
    run(4'd11, 8'h00, 8'h30, 16'h0100, 8'h0, 8'h0, 1'b0, 8'h0);
    run(4'd12, 8'h0, 8'h0, 16'h0, 8'h0, 8'h0, 1'b0, 8'h0);
    chk(next_pc == 16'h0100 && sp == 8'hFE, "R12 ret wrap", {next_pc, sp}, {16'h0100, 8'hFE});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule